// File: doc/BRIEF.md
# Field-gap pulse interval modulator

This block turns a stream of downlink symbols into on/off control of a low-frequency reader carrier. Time is counted in microsecond ticks, which arrive on a tick-enable input. Every other cycle of the clock leaves every interval unchanged.

A command begins with a start pulse. The block latches the timing set and the read-gap choice on that pulse. It then holds the field on long enough to power the tag, and opens a start gap by turning the field off. Each symbol follows as a field-on interval whose length depends on the symbol and the timing set, and each symbol is followed by a fixed field-off write gap.

One timing set puts an extra-long reference pulse ahead of the stream. Another encodes two bits per symbol on four pulse lengths. Commands that expect a reply end with a short field-on read gap, and the field then stays on for listening. Write commands end with the field off. A one-entry symbol slot is refilled while a symbol or gap is running, so back-to-back symbols need no extra time. If the upstream source runs dry, the field-off gap is stretched until the next symbol arrives.

Top module: `fgap_modulator`

## Requirements
- R1: Reset drives `field_on_o`, `busy_o`, `done_o` and `sym_ready_o` low. A reset in the middle of a command drops the field at the next clock edge.
- R2: A start pulse while idle sets `busy_o`. The field is held on for `POWER_US` ticks and then held off for a 248-tick start gap.
- R3: In timing set 0 (fixed bit) and set 1 (long reference), symbol bit 0 selects the pulse length: 0 gives 144 ticks on and 1 gives 400 ticks on. Symbol bit 1 has no effect in these sets.
- R4: In timing set 2 (leading zero), a symbol with bit 0 clear gives 144 ticks on and one with bit 0 set gives 320 ticks on. Bit 1 has no effect.
- R5: In timing set 3 (one of four), the 2-bit symbol values 0, 1, 2 and 3 give 144, 272, 400 and 528 ticks on.
- R6: Every field-on symbol pulse and the reference pulse is followed by exactly 160 ticks of field off.
- R7: In timing set 1, a 1232-tick field-on reference pulse and its 160-tick gap come between the start gap and the first stream symbol.
- R8: If `read_gap_i` was high at start, the field goes on for 120 ticks after the gap of the last symbol, and it stays on after completion. Otherwise the command ends with the field off.
- R9: `done_o` is high for exactly one cycle per completed command, in the cycle after the final interval, with `busy_o` already low.
- R10: If no symbol is held when a gap would end, the field stays off until a symbol arrives, and that symbol then gets its full pulse length.
- R11: Intervals advance only on cycles where `tick_i` is high. Cycles without a tick leave the field state unchanged.
- R12: A start pulse during a command is ignored. Changes on `mode_i` and `read_gap_i` after start do not alter the command in progress.
- R13: `sym_ready_o` is high only while busy, with the one-entry slot empty and the symbol marked last not yet taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-microsecond tick enable |
| start_i | input | 1 | Begin a command (sampled while idle) |
| mode_i | input | 2 | Timing set: 0 fixed bit, 1 long reference, 2 leading zero, 3 one of four |
| read_gap_i | input | 1 | End the command with a field-on read gap |
| sym_valid_i | input | 1 | Symbol stream valid |
| sym_i | input | 2 | Symbol value (bit 0 only, except in timing set 3) |
| sym_last_i | input | 1 | Marks the final symbol of the command |
| sym_ready_o | output | 1 | Symbol stream ready |
| field_on_o | output | 1 | Carrier enable |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench records the field waveform as a list of constant-level runs, each measured in ticks, and compares it with a list built from the requirement formulas.

Each timing set is driven with a symbol source that is always ready. Directed all-value patterns in set 3 separate the four pulse lengths. Random upper symbol bits in the binary sets show that bit 1 is ignored. A gated-off tick phase and random tick patterns show that only ticked cycles count.

A delayed source checks that the gap is stretched. A start pulse and mode change in mid-command, and a reset in mid-command, check that a running command is protected and that an abort takes effect at once.

// File: rtl/fgap_pkg.sv
package fgap_pkg;

    localparam int TIME_W = 11;
    localparam int SYM_W  = 2;

    typedef logic [TIME_W-1:0] tval_t;

    // Default interval lengths in ticks
    localparam tval_t T_START_GAP  = 11'd248;
    localparam tval_t T_WRITE_GAP  = 11'd160;
    localparam tval_t T_READ_GAP   = 11'd120;
    localparam tval_t T_SHORT      = 11'd144;
    localparam tval_t T_REF_EXTRA  = 11'd1088;
    localparam tval_t T_LONG       = 11'd400;
    localparam tval_t T_LZ_LONG    = 11'd320;
    localparam tval_t T_QUAD_STEP  = 11'd128;

    typedef enum logic [1:0] {
        DL_FIXED    = 2'd0,
        DL_LONGREF  = 2'd1,
        DL_LEADZERO = 2'd2,
        DL_QUAD     = 2'd3
    } dl_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POWER,
        ST_SGAP,
        ST_LREF,
        ST_SYM,
        ST_WGAP,
        ST_STALL,
        ST_RGAP
    } seq_state_e;

    typedef struct packed {
        tval_t start_gap;
        tval_t write_gap;
        tval_t read_gap;
        tval_t ref_on;
        tval_t on_0;
        tval_t on_1;
        tval_t on_2;
        tval_t on_3;
    } timing_t;

    function automatic timing_t mode_timing(dl_mode_e m);
        timing_t t;
        t.start_gap = T_START_GAP;
        t.write_gap = T_WRITE_GAP;
        t.read_gap  = T_READ_GAP;
        t.ref_on    = T_SHORT + T_REF_EXTRA;
        t.on_0      = T_SHORT;
        case (m)
            DL_QUAD: begin
                t.on_1 = T_SHORT + T_QUAD_STEP;
                t.on_2 = T_SHORT + (T_QUAD_STEP << 1);
                t.on_3 = T_SHORT + T_QUAD_STEP + (T_QUAD_STEP << 1);
            end
            DL_LEADZERO: begin
                t.on_1 = T_LZ_LONG;
                t.on_2 = T_LZ_LONG;
                t.on_3 = T_LZ_LONG;
            end
            default: begin
                t.on_1 = T_LONG;
                t.on_2 = T_LONG;
                t.on_3 = T_LONG;
            end
        endcase
        return t;
    endfunction

    function automatic tval_t symbol_time(timing_t t, dl_mode_e m, logic [SYM_W-1:0] s);
        tval_t v;
        if (m == DL_QUAD) begin
            case (s)
                2'd0:    v = t.on_0;
                2'd1:    v = t.on_1;
                2'd2:    v = t.on_2;
                default: v = t.on_3;
            endcase
        end else begin
            v = s[0] ? t.on_1 : t.on_0;
        end
        return v;
    endfunction

endpackage

// File: rtl/fgap_timer.sv
module fgap_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expire_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The last tick of an interval ends it
    assign expire_o = tick_i && (cnt_q == CW'(1));

endmodule

// File: rtl/fgap_symbuf.sv
module fgap_symbuf
    import fgap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             enable_i,
    input  logic             valid_i,
    input  logic [SYM_W-1:0] sym_i,
    input  logic             last_i,
    input  logic             pop_i,
    output logic             ready_o,
    output logic             full_o,
    output logic [SYM_W-1:0] sym_o,
    output logic             last_o
);

    logic             full_q;
    logic             taken_last_q;
    logic [SYM_W-1:0] sym_q;
    logic             last_q;
    logic             accept;

    assign ready_o = enable_i && !full_q && !taken_last_q;
    assign accept  = valid_i && ready_o;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            full_q       <= 1'b0;
            taken_last_q <= 1'b0;
            sym_q        <= '0;
            last_q       <= 1'b0;
        end else if (accept) begin
            full_q       <= 1'b1;
            sym_q        <= sym_i;
            last_q       <= last_i;
            taken_last_q <= last_i;
        end else if (pop_i) begin
            full_q       <= 1'b0;
        end
    end

    assign full_o = full_q;
    assign sym_o  = sym_q;
    assign last_o = last_q;

endmodule

// File: rtl/fgap_seq.sv
module fgap_seq
    import fgap_pkg::*;
#(
    parameter int CW       = 13,
    parameter int POWER_US = 5000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic             read_gap_i,
    input  logic             expire_i,
    input  logic             buf_full_i,
    input  logic [SYM_W-1:0] buf_sym_i,
    input  logic             buf_last_i,
    output logic             load_o,
    output logic [CW-1:0]    load_val_o,
    output logic             pop_o,
    output logic             clear_o,
    output logic             field_on_o,
    output logic             busy_o,
    output logic             done_o
);

    seq_state_e state_q, state_n;
    dl_mode_e   mode_q;
    timing_t    tim_q;
    logic       rd_q;
    logic       field_q, field_n;
    logic       sent_last_q, sent_last_n;
    logic       done_q, done_n;
    logic       take_sym;
    logic [CW-1:0] sym_len;

    assign sym_len = CW'(symbol_time(tim_q, mode_q, buf_sym_i));

    always_comb begin
        state_n     = state_q;
        field_n     = field_q;
        sent_last_n = sent_last_q;
        done_n      = 1'b0;
        load_o      = 1'b0;
        load_val_o  = '0;
        pop_o       = 1'b0;
        clear_o     = 1'b0;
        take_sym    = 1'b0;

        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_n     = ST_POWER;
                    load_o      = 1'b1;
                    load_val_o  = CW'(POWER_US);
                    field_n     = 1'b1;
                    sent_last_n = 1'b0;
                    clear_o     = 1'b1;
                end
            end
            ST_POWER: begin
                if (expire_i) begin
                    state_n    = ST_SGAP;
                    load_o     = 1'b1;
                    load_val_o = CW'(tim_q.start_gap);
                    field_n    = 1'b0;
                end
            end
            ST_SGAP: begin
                if (expire_i) begin
                    if (mode_q == DL_LONGREF) begin
                        state_n    = ST_LREF;
                        load_o     = 1'b1;
                        load_val_o = CW'(tim_q.ref_on);
                        field_n    = 1'b1;
                    end else begin
                        take_sym = 1'b1;
                    end
                end
            end
            ST_LREF, ST_SYM: begin
                if (expire_i) begin
                    state_n    = ST_WGAP;
                    load_o     = 1'b1;
                    load_val_o = CW'(tim_q.write_gap);
                    field_n    = 1'b0;
                end
            end
            ST_WGAP: begin
                if (expire_i) begin
                    if (sent_last_q) begin
                        if (rd_q) begin
                            state_n    = ST_RGAP;
                            load_o     = 1'b1;
                            load_val_o = CW'(tim_q.read_gap);
                            field_n    = 1'b1;
                        end else begin
                            state_n = ST_IDLE;
                            done_n  = 1'b1;
                            field_n = 1'b0;
                        end
                    end else begin
                        take_sym = 1'b1;
                    end
                end
            end
            ST_STALL: begin
                take_sym = 1'b1;
            end
            ST_RGAP: begin
                if (expire_i) begin
                    state_n = ST_IDLE;
                    done_n  = 1'b1;
                end
            end
            default: begin
                state_n = ST_IDLE;
                field_n = 1'b0;
            end
        endcase

        if (take_sym) begin
            if (buf_full_i) begin
                state_n     = ST_SYM;
                load_o      = 1'b1;
                load_val_o  = sym_len;
                pop_o       = 1'b1;
                sent_last_n = buf_last_i;
                field_n     = 1'b1;
            end else begin
                state_n = ST_STALL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            field_q     <= 1'b0;
            sent_last_q <= 1'b0;
            done_q      <= 1'b0;
            mode_q      <= DL_FIXED;
            rd_q        <= 1'b0;
            tim_q       <= '0;
        end else begin
            state_q     <= state_n;
            field_q     <= field_n;
            sent_last_q <= sent_last_n;
            done_q      <= done_n;
            if (state_q == ST_IDLE && start_i) begin
                mode_q <= dl_mode_e'(mode_i);
                rd_q   <= read_gap_i;
                tim_q  <= mode_timing(dl_mode_e'(mode_i));
            end
        end
    end

    assign field_on_o = field_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;

endmodule

// File: rtl/fgap_modulator.sv
module fgap_modulator
    import fgap_pkg::*;
#(
    parameter int POWER_US = 5000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic             read_gap_i,
    input  logic             sym_valid_i,
    input  logic [SYM_W-1:0] sym_i,
    input  logic             sym_last_i,
    output logic             sym_ready_o,
    output logic             field_on_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int PW_W = $clog2(POWER_US + 1);
    localparam int CW   = (PW_W > TIME_W) ? PW_W : TIME_W;

    logic             tmr_load;
    logic [CW-1:0]    tmr_val;
    logic             tmr_expire;
    logic             buf_full;
    logic [SYM_W-1:0] buf_sym;
    logic             buf_last;
    logic             buf_pop;
    logic             buf_clear;

    fgap_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expire_o   (tmr_expire)
    );

    fgap_symbuf u_buf (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (buf_clear),
        .enable_i (busy_o),
        .valid_i  (sym_valid_i),
        .sym_i    (sym_i),
        .last_i   (sym_last_i),
        .pop_i    (buf_pop),
        .ready_o  (sym_ready_o),
        .full_o   (buf_full),
        .sym_o    (buf_sym),
        .last_o   (buf_last)
    );

    fgap_seq #(.CW(CW), .POWER_US(POWER_US)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .read_gap_i (read_gap_i),
        .expire_i   (tmr_expire),
        .buf_full_i (buf_full),
        .buf_sym_i  (buf_sym),
        .buf_last_i (buf_last),
        .load_o     (tmr_load),
        .load_val_o (tmr_val),
        .pop_o      (buf_pop),
        .clear_o    (buf_clear),
        .field_on_o (field_on_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

endmodule

// File: rtl/fgap_modulator_chk.sv
module fgap_modulator_chk (
    input logic clk,
    input logic rst,
    input logic tick_i,
    input logic field_on_o,
    input logic busy_o,
    input logic done_o,
    input logic sym_ready_o,
    input logic buf_full
);

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!field_on_o && !busy_o && !done_o && !sym_ready_o));

    // R2
    a_r2_power_first: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> field_on_o);

    // R9
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R11
    a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !tick_i && !buf_full) |=> $stable(field_on_o));

    // R13
    a_r13_ready_busy: assert property (@(posedge clk) disable iff (rst)
        sym_ready_o |-> busy_o);

endmodule

bind fgap_modulator fgap_modulator_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .field_on_o  (field_on_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .sym_ready_o (sym_ready_o),
    .buf_full    (buf_full)
);

// File: tb/tb_fgap_modulator.sv
module tb_fgap_modulator;

    localparam int PWR   = 30;
    localparam int LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       read_gap_i = 1'b0;
    logic       sym_valid_i = 1'b0;
    logic [1:0] sym_i = 2'd0;
    logic       sym_last_i = 1'b0;
    logic       sym_ready_o, field_on_o, busy_o, done_o;

    always #2 clk = ~clk;

    fgap_modulator #(.POWER_US(PWR)) dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(start_i),
        .mode_i(mode_i), .read_gap_i(read_gap_i),
        .sym_valid_i(sym_valid_i), .sym_i(sym_i), .sym_last_i(sym_last_i),
        .sym_ready_o(sym_ready_o), .field_on_o(field_on_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit wd   = 0;

    // feeder state
    logic [1:0] fq_sym [64];
    int  fq_n = 0;
    int  fq_idx = 0;
    int  fq_hold = 0;
    int  tick_mode = 0;
    int  tick_low_left = 0;
    bit  fire = 0;

    // run recorder
    bit  run_f [64];
    int  run_c [64];
    int  nrun = 0;
    bit  rec = 0;
    bit  arm = 0;
    bit  cur_f = 0;
    int  cur_c = 0;
    int  done_cnt = 0;
    bit  last_acc = 0;
    int  rdy_after_last = 0;

    // expected runs
    bit  exp_f [64];
    int  exp_c [64];
    bit  exp_min [64];
    int  nexp = 0;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT && !wd) begin
            wd = 1;
            nchk++;
            nerr++;
            $display("FAIL R2 watchdog: actual %0d expected %0d cycles", cyc, LIMIT);
            summary();
            $finish;
        end
    end

    // Input driver, one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        case (tick_mode)
            1: tick_i = ($urandom % 2) == 1;
            2: begin
                tick_i = (tick_low_left == 0);
                if (tick_low_left > 0) tick_low_left--;
            end
            default: tick_i = 1'b1;
        endcase
        if (fire) fq_idx++;
        if (fq_hold > 0) fq_hold--;
        if (fq_idx < fq_n && fq_hold == 0) begin
            sym_valid_i = 1'b1;
            sym_i       = fq_sym[fq_idx];
            sym_last_i  = (fq_idx == fq_n - 1);
        end else begin
            sym_valid_i = 1'b0;
            sym_last_i  = 1'b0;
        end
    end

    // Monitor on falling edges
    always @(negedge clk) begin
        fire = sym_valid_i && sym_ready_o;
        if (fire && sym_last_i) last_acc = 1;
        else if (last_acc && sym_ready_o) rdy_after_last++;
        if (done_o) done_cnt++;
        if (rec) begin
            if (done_o) begin
                run_f[nrun] = cur_f; run_c[nrun] = cur_c; nrun++;
                rec = 0;
            end else if (field_on_o == cur_f) begin
                cur_c += int'(tick_i);
            end else begin
                if (nrun < 63) begin run_f[nrun] = cur_f; run_c[nrun] = cur_c; nrun++; end
                cur_f = field_on_o;
                cur_c = int'(tick_i);
            end
        end else if (arm && busy_o) begin
            arm   = 0;
            rec   = 1;
            cur_f = field_on_o;
            cur_c = int'(tick_i);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int on_time(input int mode, input logic [1:0] s);
        if (mode == 3) return 144 + 128 * int'(s);
        if (mode == 2) return s[0] ? 320 : 144;
        return s[0] ? 400 : 144;
    endfunction

    task automatic add_exp(input bit f, input int c, input bit m);
        exp_f[nexp] = f; exp_c[nexp] = c; exp_min[nexp] = m; nexp++;
    endtask

    task automatic run_seq(input int mode, input bit rd, input int n, input int tmode,
                           input int hold, input bit disturb, input bit all_vals,
                           input string req);
        for (int i = 0; i < n; i++)
            fq_sym[i] = all_vals ? 2'(i % 4) : 2'($urandom % 4);
        nexp = 0;
        add_exp(1, PWR, 0);
        if (hold > 0) add_exp(0, 400, 1);
        else          add_exp(0, 248, 0);
        if (mode == 1) begin
            add_exp(1, 1232, 0);
            add_exp(0, 160, 0);
        end
        for (int i = 0; i < n; i++) begin
            add_exp(1, on_time(mode, fq_sym[i]), 0);
            add_exp(0, 160, 0);
        end
        if (rd) add_exp(1, 120, 0);

        @(posedge clk); #1;
        fq_n = n; fq_idx = 0; fq_hold = hold; tick_mode = tmode;
        tick_low_left = (tmode == 2) ? 200 : 0;
        nrun = 0; done_cnt = 0; last_acc = 0; rdy_after_last = 0; rec = 0;
        start_i = 1; mode_i = 2'(mode); read_gap_i = rd; arm = 1;
        @(posedge clk); #1;
        start_i = 0; mode_i = 2'($urandom % 4); read_gap_i = 1'($urandom % 2);
        if (tmode == 2) begin
            repeat (150) @(posedge clk);
            #1;
            check(busy_o && field_on_o, "R11", "field frozen while no tick",
                  int'(field_on_o), 1);
        end
        if (disturb) begin
            repeat (350) @(posedge clk);
            #1;
            start_i = 1; mode_i = 2'(mode ^ 3); read_gap_i = !rd;
            @(posedge clk); #1;
            start_i = 0;
        end
        while (done_cnt == 0 && !wd) @(posedge clk);
        @(posedge clk); #1;
        check(nrun == nexp, req, "run count", nrun, nexp);
        for (int i = 0; i < nexp && i < nrun; i++) begin
            check(run_f[i] == exp_f[i], req, $sformatf("run %0d level", i),
                  int'(run_f[i]), int'(exp_f[i]));
            if (exp_min[i])
                check(run_c[i] >= exp_c[i], "R10", $sformatf("run %0d stretched ticks", i),
                      run_c[i], exp_c[i]);
            else
                check(run_c[i] == exp_c[i], req, $sformatf("run %0d ticks", i),
                      run_c[i], exp_c[i]);
        end
        check(field_on_o == rd, "R8", "field level after done", int'(field_on_o), int'(rd));
        repeat (5) @(posedge clk);
        #1;
        check(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
        check(!busy_o, "R9", "busy after done", int'(busy_o), 0);
        check(rdy_after_last == 0, "R13", "ready after last symbol", rdy_after_last, 0);
        check(!sym_ready_o, "R13", "ready while idle", int'(sym_ready_o), 0);
        fq_n = 0; fq_idx = 0;
    endtask

    initial begin
        void'($urandom(32'd7151));
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        @(negedge clk);
        check(!field_on_o && !busy_o && !done_o && !sym_ready_o, "R1", "reset state",
              int'({field_on_o, busy_o, done_o, sym_ready_o}), 0);

        run_seq(0, 0, 6, 0, 0, 0, 0, "R3");
        run_seq(0, 1, 3, 0, 0, 0, 0, "R8");
        run_seq(1, 0, 4, 0, 0, 0, 0, "R7");
        run_seq(2, 1, 5, 0, 0, 0, 0, "R4");
        run_seq(2, 0, 4, 0, 0, 0, 1, "R4");
        run_seq(3, 0, 8, 0, 0, 0, 1, "R5");
        run_seq(3, 1, 4, 0, 0, 0, 0, "R6");
        run_seq(0, 0, 3, 2, 0, 0, 0, "R11");
        run_seq(0, 0, 2, 0, 700, 0, 0, "R10");
        run_seq(3, 0, 5, 0, 0, 1, 1, "R12");
        for (int k = 0; k < 6; k++)
            run_seq(int'($urandom % 4), 1'($urandom % 2), 1 + int'($urandom % 6),
                    1, 0, 0, 0, "R11");

        // Abort with reset in mid-command
        @(posedge clk); #1;
        fq_n = 4; fq_idx = 0; fq_hold = 0; tick_mode = 0;
        fq_sym[0] = 2'd3; fq_sym[1] = 2'd3; fq_sym[2] = 2'd3; fq_sym[3] = 2'd3;
        start_i = 1; mode_i = 2'd3; read_gap_i = 1;
        @(posedge clk); #1;
        start_i = 0;
        repeat (400) @(posedge clk);
        #1;
        check(busy_o && field_on_o, "R1", "mid-command pulse before reset", int'(field_on_o), 1);
        rst = 1;
        @(posedge clk); #1;
        check(!field_on_o && !busy_o && !sym_ready_o, "R1", "field dropped by reset",
              int'({field_on_o, busy_o, sym_ready_o}), 0);
        rst = 0;
        fq_n = 0;
        repeat (5) @(posedge clk);

        summary();
        $finish;
    end

endmodule